// File: doc/BRIEF.md
# Line Loss-of-Signal Detector

This block sits behind a receive slicer path and decides whether the incoming line carries a usable signal. Once per unit interval (UI, 488 ns at 2.048 Mbit/s) the slicer path presents an attenuation estimate: an unsigned code giving how many dB the received amplitude lies below nominal, qualified by a one-cycle strobe. The block turns that stream into one loss-of-signal flag.

Two thresholds with a dead band between them give the flag hysteresis. An attenuation of 35 dB or more counts as loss. An attenuation of 12 dB or less counts as a healthy signal. Any code in between changes nothing. A state change needs an unbroken run of `PERSIST` qualifying UIs (parameter, legal range 10 to 255, default 32). This keeps both declaration and clearance inside the 10 to 255 UI reaction window. The running persistence count is brought out for debug. The flag starts asserted after reset, so a link is reported lost until good signal has been timed in.

Top module: `los_detector`

## Requirements
- R1: After reset `los` is 1 and `dbg_cnt` is 0.
- R2: While `los` is 0, `PERSIST` consecutive strobed UIs with `atten_db` >= 35 set `los` to 1 on the clock edge that samples the last of them.
- R3: While `los` is 1, `PERSIST` consecutive strobed UIs with `atten_db` <= 12 clear `los` to 0 on the clock edge that samples the last of them.
- R4: A strobed UI with `atten_db` in 13..34 leaves `los` unchanged and returns `dbg_cnt` to 0.
- R5: A single strobed UI that does not qualify for the pending change (not >= 35 while `los`=0, not <= 12 while `los`=1) restarts the run, so a full `PERSIST` further qualifying UIs are needed.
- R6: Clock cycles with `ui_stb` low change neither `los` nor `dbg_cnt`, whatever `atten_db` holds.
- R7: `dbg_cnt` (zero-extended to 8 bits) equals the number of consecutive qualifying strobed UIs seen so far, stays below `PERSIST`, and is 0 on the cycle after `los` changes.
- R8: The threshold codes are exact: 35 counts as loss and 34 does not; 12 counts as healthy and 13 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ui_stb | input | 1 | One-cycle strobe marking a new per-UI sample |
| atten_db | input | ATT_W (8) | Attenuation below nominal in dB, unsigned |
| los | output | 1 | Loss-of-signal flag, 1 while loss is declared |
| dbg_cnt | output | 8 | Current persistence count, zero-extended |

## Verification
The counter finishing a run and the flag flipping fall in the same cycle. On that edge the count must wrap to 0 rather than step past `PERSIST-1`, and the qualifying sense must invert for the next run. The bench provokes this by feeding exactly `PERSIST-1` qualifying samples, checking that the count reads `PERSIST-1` with the flag unchanged, then feeding one more. On the next sample point it checks that the flag has flipped and the count is 0. The same edge is stressed at the threshold codes 35 and 12, and with a dead-band or opposite-sense sample inserted just before the final one.

// File: rtl/los_pkg.sv
package los_pkg;

    // Width of the debug count port; large enough for any legal persistence.
    localparam int DBG_W = 8;

    // Per-UI amplitude class.
    typedef enum logic [1:0] {
        LVL_GOOD = 2'd0,
        LVL_MID  = 2'd1,
        LVL_LOST = 2'd2
    } lvl_e;

    // One classified UI sample.
    typedef struct packed {
        logic stb;
        lvl_e lvl;
    } ui_sample_t;

    // Map an attenuation value to its class using the two thresholds.
    function automatic lvl_e classify(input int unsigned att,
                                      input int unsigned decl_db,
                                      input int unsigned clr_db);
        if (att >= decl_db)      return LVL_LOST;
        else if (att <= clr_db)  return LVL_GOOD;
        else                     return LVL_MID;
    endfunction

endpackage

// File: rtl/los_level_classify.sv
module los_level_classify
    import los_pkg::*;
#(
    parameter int ATT_W   = 8,
    parameter int DECL_DB = 35,
    parameter int CLR_DB  = 12
) (
    input  logic             ui_stb,
    input  logic [ATT_W-1:0] atten_db,
    output ui_sample_t       sample
);
    always_comb begin
        sample.stb = ui_stb;
        sample.lvl = classify(int'(atten_db), DECL_DB, CLR_DB);
    end
endmodule

// File: rtl/los_persist_ctr.sv
module los_persist_ctr
    import los_pkg::*;
#(
    parameter int PERSIST = 32,
    parameter int CNT_W   = $clog2(PERSIST)
) (
    input  logic             clk,
    input  logic             rst,
    input  ui_sample_t       sample,
    input  logic             los,
    output logic             done,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERSIST - 1);

    logic qual;

    // A sample qualifies when it argues for leaving the current state.
    always_comb begin
        qual = sample.stb && (los ? (sample.lvl == LVL_GOOD)
                                  : (sample.lvl == LVL_LOST));
        done = qual && (cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (sample.stb) begin
            if (!qual || done) cnt <= '0;
            else               cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/los_flag_reg.sv
module los_flag_reg (
    input  logic clk,
    input  logic rst,
    input  logic flip,
    output logic los
);
    always_ff @(posedge clk) begin
        if (rst)       los <= 1'b1;
        else if (flip) los <= ~los;
    end
endmodule

// File: rtl/los_detector.sv
module los_detector
    import los_pkg::*;
#(
    parameter int ATT_W   = 8,
    parameter int DECL_DB = 35,
    parameter int CLR_DB  = 12,
    parameter int PERSIST = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ui_stb,
    input  logic [ATT_W-1:0] atten_db,
    output logic             los,
    output logic [DBG_W-1:0] dbg_cnt
);
    localparam int CNT_W = $clog2(PERSIST);

    ui_sample_t       sample;
    logic             done;
    logic [CNT_W-1:0] cnt;

    los_level_classify #(
        .ATT_W  (ATT_W),
        .DECL_DB(DECL_DB),
        .CLR_DB (CLR_DB)
    ) u_cls (
        .ui_stb  (ui_stb),
        .atten_db(atten_db),
        .sample  (sample)
    );

    los_persist_ctr #(
        .PERSIST(PERSIST),
        .CNT_W  (CNT_W)
    ) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .sample(sample),
        .los   (los),
        .done  (done),
        .cnt   (cnt)
    );

    los_flag_reg u_flag (
        .clk (clk),
        .rst (rst),
        .flip(done),
        .los (los)
    );

    assign dbg_cnt = DBG_W'(cnt);
endmodule

// File: rtl/los_detector_chk.sv
module los_detector_chk
    import los_pkg::*;
#(
    parameter int ATT_W   = 8,
    parameter int DECL_DB = 35,
    parameter int CLR_DB  = 12,
    parameter int PERSIST = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             ui_stb,
    input logic [ATT_W-1:0] atten_db,
    input logic             los,
    input logic [DBG_W-1:0] dbg_cnt
);
    localparam logic [ATT_W-1:0] DECL_C = ATT_W'(DECL_DB);
    localparam logic [ATT_W-1:0] CLR_C  = ATT_W'(CLR_DB);
    localparam logic [DBG_W-1:0] P_C    = DBG_W'(PERSIST);

    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (los && dbg_cnt == '0)); // R1

    AST_RISE_ON_LOSS: assert property (@(posedge clk) disable iff (rst)
        $rose(los) |-> ($past(ui_stb) && $past(atten_db) >= DECL_C)); // R2

    AST_FALL_ON_GOOD: assert property (@(posedge clk) disable iff (rst)
        $fell(los) |-> ($past(ui_stb) && $past(atten_db) <= CLR_C)); // R3

    AST_MID_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (ui_stb && atten_db > CLR_C && atten_db < DECL_C)
        |=> ($stable(los) && dbg_cnt == '0)); // R4

    AST_FULL_RUN: assert property (@(posedge clk) disable iff (rst)
        (los != $past(los)) |-> ($past(dbg_cnt) == P_C - 1'b1)); // R5

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !ui_stb |=> ($stable(los) && $stable(dbg_cnt))); // R6

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        dbg_cnt < P_C); // R7
endmodule

bind los_detector los_detector_chk #(
    .ATT_W  (ATT_W),
    .DECL_DB(DECL_DB),
    .CLR_DB (CLR_DB),
    .PERSIST(PERSIST)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ui_stb  (ui_stb),
    .atten_db(atten_db),
    .los     (los),
    .dbg_cnt (dbg_cnt)
);

// File: tb/los_detector_tb.sv
module los_detector_tb;
    localparam int CLK_PERIOD = 10;
    localparam int P = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ui_stb = 1'b0;
    logic [7:0] atten_db = 8'd0;
    logic       los;
    logic [7:0] dbg_cnt;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    los_detector #(.PERSIST(P)) u_dut (
        .clk(clk), .rst(rst), .ui_stb(ui_stb), .atten_db(atten_db),
        .los(los), .dbg_cnt(dbg_cnt)
    );

    task automatic check(input string req, input string what,
                         input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    // Present n strobed UIs with value a, each followed by gap idle cycles.
    task automatic send(input int n, input int a, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ui_stb = 1'b1; atten_db = 8'(a);
            @(negedge clk); ui_stb = 1'b0;
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
    endtask

    task automatic do_reset;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_reset;
        do_reset();
        check("R1", "los after reset", los, 1);
        check("R1", "count after reset", dbg_cnt, 0);
    endtask

    task automatic t_clear;
        do_reset();
        send(P-1, 0, 0);
        check("R7", "count before clear", dbg_cnt, P-1);
        check("R3", "los held before full run", los, 1);
        send(1, 0, 0);
        check("R3", "los cleared after full run", los, 0);
        check("R7", "count wraps on clear", dbg_cnt, 0);
    endtask

    task automatic t_declare_edges;   // starts with los=0
        send(P, 34, 0);
        check("R8", "34 dB is not loss", los, 0);
        check("R8", "34 dB does not count", dbg_cnt, 0);
        send(P-1, 35, 1);
        check("R7", "count at 35 dB run", dbg_cnt, P-1);
        send(1, 20, 0);
        check("R4", "mid restarts count", dbg_cnt, 0);
        check("R5", "los held after break", los, 0);
        send(P-1, 35, 0);
        check("R5", "los still 0 short of fresh run", los, 0);
        send(1, 35, 0);
        check("R2", "los set after full run", los, 1);
        check("R8", "35 dB counts as loss", los, 1);
    endtask

    task automatic t_clear_edges;     // starts with los=1
        send(P, 13, 0);
        check("R8", "13 dB is not healthy", los, 1);
        send(P-1, 12, 0);
        check("R7", "count at 12 dB run", dbg_cnt, P-1);
        send(1, 40, 0);
        check("R5", "opposite UI restarts", dbg_cnt, 0);
        check("R5", "los held after break", los, 1);
        send(P, 12, 0);
        check("R8", "12 dB counts as healthy", los, 0);
    endtask

    task automatic t_idle;            // starts with los=0
        send(P-1, 50, 0);
        @(negedge clk); atten_db = 8'd50;
        for (int i = 0; i < 100; i++) @(negedge clk);
        check("R6", "los unchanged without strobe", los, 0);
        check("R6", "count unchanged without strobe", dbg_cnt, P-1);
        send(1, 50, 2);
        check("R2", "los set on last strobe", los, 1);
    endtask

    task automatic t_mid_hold;        // starts with los=1
        send(40, 20, 0);
        check("R4", "mid keeps los=1", los, 1);
        send(P, 0, 0);
        check("R3", "cleared", los, 0);
        send(40, 25, 0);
        check("R4", "mid keeps los=0", los, 0);
        check("R4", "mid count stays 0", dbg_cnt, 0);
    endtask

    initial begin
        t_reset();
        t_clear();
        t_declare_edges();
        t_clear_edges();
        t_idle();
        t_mid_hold();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule